// File: doc/BRIEF.md
# Indirect Register Access Sequencer

This block turns one user request into the whole series of memory-mapped transactions that an indirect register bridge expects. A request names a target lane (channel), a setting register inside that lane, write data and a read-or-write choice. The block drives a memory-mapped master port to carry it out. It waits until the bridge is idle. It loads the bridge's channel, register-address and data holding registers. It issues a start command, and it waits until the bridge reports completion. For a read it then fetches the result from the bridge's data holding register.

The user side is a level request held until a one-cycle acknowledge. The acknowledge carries read data and three error flags. Two flags are reported by the bridge: bad channel and bad register address. The third is a local poll timeout. The block remembers the channel and register address of the last access that succeeded. When a new request targets the same pair, the two setup writes are left out. While a sequence runs, the block drives the bridge's mode select to the value that routes the port to the equalizer settings.

Top module: `iam_sequencer`

## Requirements
- R1: After a request is accepted, the first bus transaction is a read of offset 0 (control/status). No write is issued while the last status read returned bit 15 (busy) set, so the status read repeats until bit 15 reads 0.
- R2: The setup writes come in this order: channel to offset 1, register address to offset 2, and (writes only) data to offset 3. Then a start write to offset 0 follows, with bit 0 = 1 and bit 1 = 1 for a read or 0 for a write. All other bits are 0.
- R3: After the start write, offset 0 is read repeatedly until bit 15 is clear. For a read without error, offset 3 is then read and its value is returned on `ack_rdata`.
- R4: When channel and register address both equal those of the last access that finished without error, the writes to offsets 1 and 2 are skipped.
- R5: Bit 13 and bit 14 of the final status read are returned as `ack_flags[0]` (bad channel) and `ack_flags[1]` (bad register). If either is set, the data fetch is skipped and `ack_rdata` is 0.
- R6: If a poll loop sees POLL_LIMIT consecutive busy reads, the sequence ends with `ack_flags[2]` set. `ack_err` is the OR of the three flags.
- R7: After any access that ends with a flag set, the remembered pair is invalid, so the next access performs both setup writes.
- R8: `mode_sel` is 4'b1100 in every cycle a bus transaction is in progress and 4'b0000 while idle.
- R9: While `mm_waitreq` is high during a transaction, `mm_addr`, `mm_read`, `mm_write` and `mm_wdata` stay unchanged. Read and write are never high together.
- R10: `req_ack` is high for exactly one cycle per accepted request. A new request is sampled only while the block is idle.
- R11: Directly after reset, `req_ack`, `mm_read`, `mm_write` are 0 and `mode_sel` is 4'b0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request, held until `req_ack` |
| req_rd | input | 1 | 1 = read, 0 = write |
| req_chan | input | 16 | Target channel |
| req_sreg | input | 16 | Setting register address |
| req_wdata | input | 16 | Data for writes |
| req_ack | output | 1 | One-cycle completion pulse |
| ack_rdata | output | 16 | Read result, valid with `req_ack` |
| ack_flags | output | 3 | {timeout, bad register, bad channel} |
| ack_err | output | 1 | Any flag set |
| mode_sel | output | 4 | Bridge mode select |
| mm_addr | output | ADDR_W | Master address |
| mm_read | output | 1 | Master read strobe |
| mm_write | output | 1 | Master write strobe |
| mm_wdata | output | 16 | Master write data |
| mm_rdata | input | 16 | Read data, valid when read and not waitreq |
| mm_waitreq | input | 1 | Slave stall |

## Verification
The acknowledge has no fixed latency. It depends on stall cycles, on how many busy polls occur and on whether setup is skipped. The bench therefore waits for `req_ack` at falling edges and samples result and flags in that cycle. It then checks one cycle later that the pulse has ended. Bus order is checked from a log, kept by the bench's bridge model, of completed transactions with consecutive repeats merged, so the order does not depend on how many polls occurred. Timeout is checked by counting the busy status reads, which must equal POLL_LIMIT exactly.

// File: rtl/iam_pkg.sv
package iam_pkg;

    localparam int unsigned REG_W       = 16;
    localparam int unsigned OFS_CSR     = 0;
    localparam int unsigned OFS_CHAN    = 1;
    localparam int unsigned OFS_SREG    = 2;
    localparam int unsigned OFS_DATA    = 3;
    localparam int unsigned BIT_GO      = 0;
    localparam int unsigned BIT_RDNW    = 1;
    localparam int unsigned BIT_ERR_CH  = 13;
    localparam int unsigned BIT_ERR_RG  = 14;
    localparam int unsigned BIT_BUSY    = 15;
    localparam logic [3:0]  MODE_ACTIVE = 4'b1100;
    localparam logic [3:0]  MODE_IDLE   = 4'b0000;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PRE_POLL,
        ST_SET_CHAN,
        ST_SET_SREG,
        ST_SET_DATA,
        ST_KICK,
        ST_POST_POLL,
        ST_GET_DATA,
        ST_RESP
    } seq_state_e;

    typedef struct packed {
        logic timeout;
        logic reg_err;
        logic chan_err;
    } flags_t;

    typedef struct packed {
        logic             rd;
        logic [REG_W-1:0] chan;
        logic [REG_W-1:0] sreg;
        logic [REG_W-1:0] wdata;
    } req_t;

    function automatic logic [REG_W-1:0] kick_word(input logic rd);
        logic [REG_W-1:0] w;
        w           = '0;
        w[BIT_GO]   = 1'b1;
        w[BIT_RDNW] = rd;
        return w;
    endfunction

endpackage

// File: rtl/iam_mm_port.sv
module iam_mm_port #(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              launch,
    input  logic              launch_rd,
    input  logic [ADDR_W-1:0] launch_addr,
    input  logic [DATA_W-1:0] launch_wdata,
    output logic              done,
    output logic [ADDR_W-1:0] mm_addr,
    output logic              mm_read,
    output logic              mm_write,
    output logic [DATA_W-1:0] mm_wdata,
    input  logic              mm_waitreq
);
    logic active;
    assign active = mm_read | mm_write;
    assign done   = active & ~mm_waitreq;

    always_ff @(posedge clk) begin
        if (rst) begin
            mm_addr  <= '0;
            mm_read  <= 1'b0;
            mm_write <= 1'b0;
            mm_wdata <= '0;
        end else if (done) begin
            mm_read  <= 1'b0;
            mm_write <= 1'b0;
        end else if (launch && !active) begin
            mm_addr  <= launch_addr;
            mm_read  <= launch_rd;
            mm_write <= ~launch_rd;
            mm_wdata <= launch_wdata;
        end
    end
endmodule

// File: rtl/iam_poll_timer.sv
module iam_poll_timer #(
    parameter int unsigned LIMIT = 1024
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic step,
    output logic last
);
    localparam int unsigned CW = $clog2(LIMIT + 1);
    logic [CW-1:0] cnt;

    assign last = (cnt == CW'(LIMIT - 1));

    always_ff @(posedge clk) begin
        if (rst || clr) cnt <= '0;
        else if (step)  cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/iam_setup_cache.sv
module iam_setup_cache #(
    parameter int unsigned KEY_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             upd,
    input  logic             upd_ok,
    input  logic [KEY_W-1:0] chan,
    input  logic [KEY_W-1:0] sreg,
    output logic             hit
);
    logic             valid_q;
    logic [KEY_W-1:0] chan_q;
    logic [KEY_W-1:0] sreg_q;

    assign hit = valid_q && (chan_q == chan) && (sreg_q == sreg);

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            chan_q  <= '0;
            sreg_q  <= '0;
        end else if (upd) begin
            valid_q <= upd_ok;
            chan_q  <= chan;
            sreg_q  <= sreg;
        end
    end
endmodule

// File: rtl/iam_sequencer.sv
module iam_sequencer
    import iam_pkg::*;
#(
    parameter int unsigned ADDR_W     = 16,
    parameter int unsigned POLL_LIMIT = 1024
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_rd,
    input  logic [REG_W-1:0]  req_chan,
    input  logic [REG_W-1:0]  req_sreg,
    input  logic [REG_W-1:0]  req_wdata,
    output logic              req_ack,
    output logic [REG_W-1:0]  ack_rdata,
    output logic [2:0]        ack_flags,
    output logic              ack_err,
    output logic [3:0]        mode_sel,
    output logic [ADDR_W-1:0] mm_addr,
    output logic              mm_read,
    output logic              mm_write,
    output logic [REG_W-1:0]  mm_wdata,
    input  logic [REG_W-1:0]  mm_rdata,
    input  logic              mm_waitreq
);
    seq_state_e        state;
    req_t              req_q;
    flags_t            flags_q;
    logic [REG_W-1:0]  rdata_q;
    logic              launched;

    logic              launch, l_rd, op_done;
    logic [ADDR_W-1:0] l_addr;
    logic [REG_W-1:0]  l_wdata;
    logic              in_poll, busy_seen, poll_step, poll_clr, poll_last;
    logic              hit;

    iam_mm_port #(.ADDR_W(ADDR_W), .DATA_W(REG_W)) u_port (
        .clk(clk), .rst(rst),
        .launch(launch), .launch_rd(l_rd), .launch_addr(l_addr), .launch_wdata(l_wdata),
        .done(op_done),
        .mm_addr(mm_addr), .mm_read(mm_read), .mm_write(mm_write), .mm_wdata(mm_wdata),
        .mm_waitreq(mm_waitreq)
    );

    assign in_poll   = (state == ST_PRE_POLL) || (state == ST_POST_POLL);
    assign busy_seen = mm_rdata[BIT_BUSY];
    assign poll_step = in_poll && op_done && busy_seen;
    assign poll_clr  = (state == ST_IDLE) || (state == ST_KICK);

    iam_poll_timer #(.LIMIT(POLL_LIMIT)) u_timer (
        .clk(clk), .rst(rst), .clr(poll_clr), .step(poll_step), .last(poll_last)
    );

    iam_setup_cache #(.KEY_W(REG_W)) u_cache (
        .clk(clk), .rst(rst),
        .upd(state == ST_RESP), .upd_ok(flags_q == '0),
        .chan(req_q.chan), .sreg(req_q.sreg), .hit(hit)
    );

    // transaction selection per state
    always_comb begin
        launch  = 1'b0;
        l_rd    = 1'b0;
        l_addr  = '0;
        l_wdata = '0;
        unique case (state)
            ST_PRE_POLL, ST_POST_POLL: begin
                launch = ~launched; l_rd = 1'b1; l_addr = ADDR_W'(OFS_CSR);
            end
            ST_SET_CHAN: begin
                launch = ~launched; l_addr = ADDR_W'(OFS_CHAN); l_wdata = req_q.chan;
            end
            ST_SET_SREG: begin
                launch = ~launched; l_addr = ADDR_W'(OFS_SREG); l_wdata = req_q.sreg;
            end
            ST_SET_DATA: begin
                launch = ~launched; l_addr = ADDR_W'(OFS_DATA); l_wdata = req_q.wdata;
            end
            ST_KICK: begin
                launch = ~launched; l_addr = ADDR_W'(OFS_CSR); l_wdata = kick_word(req_q.rd);
            end
            ST_GET_DATA: begin
                launch = ~launched; l_rd = 1'b1; l_addr = ADDR_W'(OFS_DATA);
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            req_q    <= '0;
            flags_q  <= '0;
            rdata_q  <= '0;
            launched <= 1'b0;
        end else begin
            if (launch)       launched <= 1'b1;
            else if (op_done) launched <= 1'b0;

            unique case (state)
                ST_IDLE: if (req_valid) begin
                    req_q   <= '{rd: req_rd, chan: req_chan, sreg: req_sreg, wdata: req_wdata};
                    flags_q <= '0;
                    rdata_q <= '0;
                    state   <= ST_PRE_POLL;
                end
                ST_PRE_POLL: if (op_done) begin
                    if (busy_seen) begin
                        if (poll_last) begin
                            flags_q.timeout <= 1'b1;
                            state           <= ST_RESP;
                        end
                    end else if (!hit) begin
                        state <= ST_SET_CHAN;
                    end else begin
                        state <= req_q.rd ? ST_KICK : ST_SET_DATA;
                    end
                end
                ST_SET_CHAN: if (op_done) state <= ST_SET_SREG;
                ST_SET_SREG: if (op_done) state <= req_q.rd ? ST_KICK : ST_SET_DATA;
                ST_SET_DATA: if (op_done) state <= ST_KICK;
                ST_KICK:     if (op_done) state <= ST_POST_POLL;
                ST_POST_POLL: if (op_done) begin
                    if (busy_seen) begin
                        if (poll_last) begin
                            flags_q.timeout <= 1'b1;
                            state           <= ST_RESP;
                        end
                    end else begin
                        flags_q.chan_err <= mm_rdata[BIT_ERR_CH];
                        flags_q.reg_err  <= mm_rdata[BIT_ERR_RG];
                        if (req_q.rd && !mm_rdata[BIT_ERR_CH] && !mm_rdata[BIT_ERR_RG])
                            state <= ST_GET_DATA;
                        else
                            state <= ST_RESP;
                    end
                end
                ST_GET_DATA: if (op_done) begin
                    rdata_q <= mm_rdata;
                    state   <= ST_RESP;
                end
                ST_RESP: state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign req_ack   = (state == ST_RESP);
    assign ack_rdata = rdata_q;
    assign ack_flags = flags_q;
    assign ack_err   = |flags_q;
    assign mode_sel  = (state == ST_IDLE) ? MODE_IDLE : MODE_ACTIVE;

endmodule

// File: rtl/iam_seq_chk.sv
module iam_seq_chk
    import iam_pkg::*;
#(
    parameter int unsigned ADDR_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              req_ack,
    input logic [3:0]        mode_sel,
    input logic [ADDR_W-1:0] mm_addr,
    input logic              mm_read,
    input logic              mm_write,
    input logic [REG_W-1:0]  mm_wdata,
    input logic              mm_waitreq
);
    // R9
    hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
        ((mm_read || mm_write) && mm_waitreq) |=>
            ($stable(mm_addr) && $stable(mm_read) && $stable(mm_write) && $stable(mm_wdata)));

    // R9
    no_dual_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        !(mm_read && mm_write));

    // R10
    ack_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        req_ack |=> !req_ack);

    // R8
    mode_active_chk: assert property (@(posedge clk) disable iff (rst)
        (mm_read || mm_write) |-> (mode_sel == MODE_ACTIVE));

    // R2
    kick_format_chk: assert property (@(posedge clk) disable iff (rst)
        (mm_write && mm_addr == ADDR_W'(OFS_CSR)) |->
            (mm_wdata[BIT_GO] && (mm_wdata[REG_W-1:2] == '0)));
endmodule

bind iam_sequencer iam_seq_chk #(.ADDR_W(ADDR_W)) u_seq_chk (
    .clk(clk), .rst(rst), .req_ack(req_ack), .mode_sel(mode_sel),
    .mm_addr(mm_addr), .mm_read(mm_read), .mm_write(mm_write),
    .mm_wdata(mm_wdata), .mm_waitreq(mm_waitreq)
);

// File: tb/test_iam_sequencer.sv
module test_iam_sequencer;
    localparam int LIMIT = 16;
    localparam logic [2:0] R0 = 3'b000, R3 = 3'b011, W0 = 3'b100, W1 = 3'b101,
                           W2 = 3'b110, W3 = 3'b111;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0, req_rd = 1'b0;
    logic [15:0] req_chan = '0, req_sreg = '0, req_wdata = '0;
    logic        req_ack, ack_err, mm_read, mm_write, mm_waitreq;
    logic [15:0] ack_rdata, mm_wdata, mm_addr, mm_rdata;
    logic [2:0]  ack_flags;
    logic [3:0]  mode_sel;

    int n_chk = 0, n_fail = 0, cyc = 0;

    always #5 clk = ~clk;

    iam_sequencer #(.ADDR_W(16), .POLL_LIMIT(LIMIT)) i_iam_sequencer (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_rd(req_rd),
        .req_chan(req_chan), .req_sreg(req_sreg), .req_wdata(req_wdata),
        .req_ack(req_ack), .ack_rdata(ack_rdata), .ack_flags(ack_flags), .ack_err(ack_err),
        .mode_sel(mode_sel), .mm_addr(mm_addr), .mm_read(mm_read), .mm_write(mm_write),
        .mm_wdata(mm_wdata), .mm_rdata(mm_rdata), .mm_waitreq(mm_waitreq)
    );

    // ---------------- bridge model ----------------
    logic [15:0] store [0:15];
    logic [15:0] chan_r, sreg_r, data_r, last_kick;
    logic        err_ch, err_rg, rdnw;
    int          busy_cnt, busy_cfg = 3, stall_cnt, stall_cfg = 0;
    logic        preload_req = 1'b0;
    int          preload_n = 0;
    logic [2:0]  log_q [0:15];
    int          log_n, n_w1, n_w2, n_busy_rd, wr_busy_viol, mode_bad;
    logic        log_clr = 1'b0;

    assign mm_waitreq = (mm_read || mm_write) && (stall_cnt != 0);
    always_comb begin
        case (mm_addr[1:0])
            2'd0:    mm_rdata = {busy_cnt != 0, err_rg, err_ch, 13'b0};
            2'd1:    mm_rdata = chan_r;
            2'd2:    mm_rdata = sreg_r;
            default: mm_rdata = data_r;
        endcase
    end

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 16; i++) store[i] <= 16'hA000 | 16'(i);
            chan_r <= 0; sreg_r <= 0; data_r <= 0; last_kick <= 0;
            err_ch <= 0; err_rg <= 0; rdnw <= 0; busy_cnt <= 0; stall_cnt <= 0;
            log_n <= 0; n_w1 <= 0; n_w2 <= 0; n_busy_rd <= 0; wr_busy_viol <= 0; mode_bad <= 0;
        end else begin
            if (log_clr) begin
                log_n <= 0; n_w1 <= 0; n_w2 <= 0; n_busy_rd <= 0; wr_busy_viol <= 0;
            end
            if (preload_req) busy_cnt <= preload_n;
            else if (busy_cnt != 0) begin
                busy_cnt <= busy_cnt - 1;
                if (busy_cnt == 1) begin
                    if (chan_r >= 4) err_ch <= 1'b1;
                    if (sreg_r >= 3) err_rg <= 1'b1;
                    if (chan_r < 4 && sreg_r < 3) begin
                        if (rdnw) data_r <= store[{chan_r[1:0], sreg_r[1:0]}];
                        else      store[{chan_r[1:0], sreg_r[1:0]}] <= data_r;
                    end
                end
            end
            if (mm_read || mm_write) begin
                if (mode_sel != 4'b1100) mode_bad <= mode_bad + 1;
                if (stall_cnt != 0) stall_cnt <= stall_cnt - 1;
                else begin
                    stall_cnt <= stall_cfg;
                    if (!log_clr && (log_n == 0 || log_q[log_n-1] != {mm_write, mm_addr[1:0]})
                        && log_n < 16) begin
                        log_q[log_n] <= {mm_write, mm_addr[1:0]};
                        log_n <= log_n + 1;
                    end
                    if (mm_read && mm_addr == 0 && busy_cnt != 0) n_busy_rd <= n_busy_rd + 1;
                    if (mm_write && busy_cnt != 0) wr_busy_viol <= wr_busy_viol + 1;
                    else if (mm_write) begin
                        case (mm_addr[1:0])
                            2'd1: begin chan_r <= mm_wdata; n_w1 <= n_w1 + 1; end
                            2'd2: begin sreg_r <= mm_wdata; n_w2 <= n_w2 + 1; end
                            2'd3: data_r <= mm_wdata;
                            default: if (mm_wdata[0]) begin
                                busy_cnt <= busy_cfg; rdnw <= mm_wdata[1];
                                err_ch <= 0; err_rg <= 0; last_kick <= mm_wdata;
                            end
                        endcase
                    end
                end
            end
        end
    end

    // ---------------- helpers ----------------
    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic check_seq(input int n, input logic [17:0] exp, input string req);
        bit ok = (log_n == n);
        for (int i = 0; i < n && i < 6; i++)
            if (ok && log_q[i] != exp[3*(5-i) +: 3]) ok = 0;
        check(ok, req, "bus order", log_n, n);
    endtask

    task automatic access(input bit rd, input logic [15:0] ch, input logic [15:0] sr,
                          input logic [15:0] wd, output logic [15:0] rdat,
                          output logic [2:0] flg);
        int wait_n = 0;
        @(negedge clk); log_clr = 1'b1;
        @(negedge clk); log_clr = 1'b0;
        req_rd = rd; req_chan = ch; req_sreg = sr; req_wdata = wd; req_valid = 1'b1;
        while (!req_ack && wait_n < 5000) begin @(negedge clk); wait_n++; end
        rdat = ack_rdata; flg = ack_flags;
        check(req_ack == 1'b1, "R10", "ack seen", req_ack, 1);
        check(ack_err == (flg != 0), "R6", "err is flag OR", ack_err, flg != 0);
        req_valid = 1'b0;
        @(negedge clk);
        // R10 one-cycle pulse
        check(req_ack == 1'b0, "R10", "ack pulse width", req_ack, 0);
        check(mode_sel == 4'b0000, "R8", "mode idle", mode_sel, 0);
    endtask

    task automatic preload(input int n);
        @(negedge clk); preload_n = n; preload_req = 1'b1;
        @(negedge clk); preload_req = 1'b0;
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        check(req_ack == 0 && mm_read == 0 && mm_write == 0, "R11", "strobes after reset",
              {req_ack, mm_read, mm_write}, 0);
        check(mode_sel == 4'b0000, "R11", "mode after reset", mode_sel, 0);
    endtask

    task automatic t_write_fresh();
        logic [15:0] d; logic [2:0] f;
        access(0, 16'd1, 16'd0, 16'h0005, d, f);
        check(f == 0, "R5", "flags", f, 0);
        check_seq(6, {R0, W1, W2, W3, W0, R0}, "R2");
        check(last_kick == 16'h0001, "R2", "start word write", last_kick, 1);
    endtask

    task automatic t_read_cached();
        logic [15:0] d; logic [2:0] f;
        access(1, 16'd1, 16'd0, 16'h0, d, f);
        check(d == 16'h0005, "R3", "read data", d, 5);
        check(n_w1 == 0 && n_w2 == 0, "R4", "setup skipped", n_w1 + n_w2, 0);
        check_seq(4, {R0, W0, R0, R3, 6'b0}, "R4");
        check(last_kick == 16'h0003, "R2", "start word read", last_kick, 3);
    endtask

    task automatic t_read_new();
        logic [15:0] d; logic [2:0] f;
        access(1, 16'd2, 16'd2, 16'h0, d, f);
        check(d == 16'hA00A, "R3", "read data other reg", d, 16'hA00A);
        check_seq(6, {R0, W1, W2, W0, R0, R3}, "R2");
    endtask

    task automatic t_bad_chan();
        logic [15:0] d; logic [2:0] f;
        access(0, 16'd9, 16'd1, 16'h1111, d, f);
        check(f == 3'b001, "R5", "bad channel flag", f, 1);
        access(0, 16'd9, 16'd1, 16'h1111, d, f);
        check(n_w1 == 1 && n_w2 == 1, "R7", "setup redone after error", n_w1 + n_w2, 2);
    endtask

    task automatic t_bad_reg();
        logic [15:0] d; logic [2:0] f;
        access(1, 16'd0, 16'd5, 16'h0, d, f);
        check(f == 3'b010, "R5", "bad register flag", f, 2);
        check(d == 16'h0, "R5", "no data on error", d, 0);
        check_seq(5, {R0, W1, W2, W0, R0, 3'b0}, "R5");
    endtask

    task automatic t_prebusy();
        logic [15:0] d; logic [2:0] f;
        preload(8);
        access(0, 16'd3, 16'd1, 16'h1234, d, f);
        check(wr_busy_viol == 0, "R1", "no write while busy", wr_busy_viol, 0);
        check(n_busy_rd >= 1 && log_q[0] == R0, "R1", "busy polls before setup", n_busy_rd, 1);
        access(1, 16'd3, 16'd1, 16'h0, d, f);
        check(d == 16'h1234, "R1", "data after busy wait", d, 16'h1234);
    endtask

    task automatic t_stall();
        logic [15:0] d; logic [2:0] f;
        stall_cfg = 3;
        access(0, 16'd0, 16'd0, 16'hBEEF, d, f);
        access(1, 16'd0, 16'd0, 16'h0, d, f);
        check(d == 16'hBEEF && f == 0, "R9", "data through stalls", d, 16'hBEEF);
        stall_cfg = 0;
    endtask

    task automatic t_timeout();
        logic [15:0] d; logic [2:0] f;
        busy_cfg = 1000;
        access(0, 16'd2, 16'd0, 16'h7777, d, f);
        check(f == 3'b100, "R6", "timeout flag", f, 4);
        check(n_busy_rd == LIMIT, "R6", "busy poll count", n_busy_rd, LIMIT);
        preload(0);
        busy_cfg = 3;
        access(0, 16'd2, 16'd0, 16'h7777, d, f);
        check(f == 0 && n_w1 == 1, "R7", "setup after timeout", n_w1, 1);
        check(mode_bad == 0, "R8", "mode during transfers", mode_bad, 0);
    endtask

    initial begin
        while (1) begin
            @(posedge clk); cyc++;
            if (cyc > 150000) begin
                n_chk++; n_fail++;
                $display("FAIL watchdog: actual %0d expected <150000 cycles", cyc);
                $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_write_fresh();
        t_read_cached();
        t_read_new();
        t_bad_chan();
        t_bad_reg();
        t_prebusy();
        t_stall();
        t_timeout();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule